// File: doc/BRIEF.md
# Rate-Adapting User-Bit Autobuffer

This block carries the user-data bit stream and the channel-status bit of a digital audio receiver across to a transmitter that may be clocked at a different frame rate. Received user bits enter a small bit FIFO on a receive strobe, and the transmitter takes one bit from the block each time it raises its bit-request strobe.

When the rate-adapting mode is on, the stream is read as IEC 60958-3 user data. An information unit (IU) is eight bits and starts with a 1. Any 0 found where an IU start is expected is a stuffing zero, and a run of eight or more such zeros marks the end of a message. The transmit side adds stuffing zeros when the FIFO runs low. The receive side drops stuffing zeros when the FIFO runs high. It drops zeros from long inter-message gaps first, and drops zeros between IUs only when the FIFO is close to full. IUs are never split or altered. When the mode is off, the FIFO is a plain bit pipe. It sends 0 when it is empty and discards bits that arrive while it is full. Separate enables gate the user-bit copy and the channel-status copy.

Top module: `ubAutobuf`

## Requirements
- R1: After reset, txUbit and txCs are 0.
- R2: While ubCopyEn is 0 the FIFO is emptied and txUbit is 0. Bits presented during that time are not stored, so a request made after re-enabling in plain mode returns 0.
- R3: txCs equals the rxCs value captured at the latest rxValid while csCopyEn is 1, and is 0 while csCopyEn is 0.
- R4: In plain mode (stuffEn=0), txUbit presents the stored bits in arrival order. Each value appears in the cycle after the txReq that takes it.
- R5: In plain mode, a txReq on an empty FIFO yields 0. Bits that arrive while the 64-entry FIFO is full are discarded.
- R6: In stuffing mode, every IU (a 1 followed by 7 bits) leaves as 8 consecutive transmitted bits, in order and unchanged, with no stuffing inside it.
- R7: In stuffing mode, a txReq at an IU boundary while fewer than 8 bits are stored yields an inserted 0 and takes nothing from the FIFO.
- R8: In stuffing mode, with at least 48 bits stored, a received stuffing zero is dropped if 8 or more stuffing zeros directly precede it, so a message gap shrinks to exactly 8.
- R9: In stuffing mode, with at least 56 bits stored, every received stuffing zero is dropped, including zeros between IUs.
- R10: In stuffing mode, with fewer than 48 bits stored, every received stuffing zero is kept.
- R11: No bit is written into a full FIFO and no bit is read from an empty one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ubCopyEn | input | 1 | Enables the user-bit copy; when 0, flushes the FIFO |
| csCopyEn | input | 1 | Enables the channel-status copy |
| stuffEn | input | 1 | Selects stuffing mode (1) or plain mode (0) |
| rxValid | input | 1 | Receive strobe, one bit per pulse |
| rxUbit | input | 1 | Received user bit |
| rxCs | input | 1 | Received channel-status bit |
| txReq | input | 1 | Transmitter bit request |
| txUbit | output | 1 | Transmitted user bit, updated the cycle after txReq |
| txCs | output | 1 | Transmitted channel-status bit |

## Verification
The hardest state to reach from the ports is a FIFO held in the band of 48 to 63 stored bits while a stuffing-zero run crosses the 8-zero message threshold. That band is where the choice between dropping message-gap zeros and dropping inter-IU zeros is made. Directed cases fill the FIFO to exact levels with whole IUs and no transmit requests, then feed counted zero runs and drain the FIFO to compare the exact bit sequence. Random phases with a fixed seed make the receiver either slightly faster or slightly slower than the transmitter over thousands of cycles. They parse the transmitted stream back into IUs and compare it with the list of IUs that were sent.

// File: rtl/ubAutobufPkg.sv
package ubAutobufPkg;
  typedef struct packed {
    logic push;
    logic pushBit;
    logic pop;
    logic emit0;
    logic flush;
  } ctlStrobes_t;
endpackage

// File: rtl/ubDatapath.sv
module ubDatapath
  import ubAutobufPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t st,
  input  logic        rxValid,
  input  logic        rxCs,
  input  logic        csCopyEn,
  output logic [AW:0] level,
  output logic        headBit,
  output logic        txUbit,
  output logic        txCs
);
  localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);

  logic [DEPTH-1:0] memBits;
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             csHeld;

  assign headBit = memBits[rdPtr];
  assign txCs    = csCopyEn & csHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memBits <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      txUbit  <= 1'b0;
    end else if (st.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      txUbit <= 1'b0;
    end else begin
      if (st.push) begin
        memBits[wrPtr] <= st.pushBit;
        wrPtr          <= wrPtr + 1'b1;
      end
      if (st.pop) begin
        rdPtr  <= rdPtr + 1'b1;
        txUbit <= memBits[rdPtr];
      end else if (st.emit0) begin
        txUbit <= 1'b0;
      end
      case ({st.push, st.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) csHeld <= 1'b0;
    else if (rxValid && csCopyEn) csHeld <= rxCs;
  end

  // R11: the control never writes a full FIFO
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    st.push |-> level != FULL_L);
  // R11: the control never reads an empty FIFO
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    st.pop |-> level != '0);
  // R7: an inserted zero reaches the output
  assert_emit_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.emit0 && !st.pop) |=> !txUbit);
  // R2: a flush clears the output
  assert_flush_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.flush |=> (!txUbit && level == '0));
endmodule

// File: rtl/ubControl.sv
module ubControl
  import ubAutobufPkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int IU_BITS = 8,
  parameter int GAP     = 8,
  parameter int LOW     = 8,
  parameter int HIGH    = 48,
  parameter int CRIT    = 56,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(IU_BITS),
  localparam int ZW = $clog2(GAP + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ubCopyEn,
  input  logic        stuffEn,
  input  logic        rxValid,
  input  logic        rxUbit,
  input  logic        txReq,
  input  logic [AW:0] level,
  input  logic        headBit,
  output ctlStrobes_t st
);
  localparam logic [AW:0]   FULL_L  = (AW+1)'(DEPTH);
  localparam logic [AW:0]   LOW_L   = (AW+1)'(LOW);
  localparam logic [AW:0]   HIGH_L  = (AW+1)'(HIGH);
  localparam logic [AW:0]   CRIT_L  = (AW+1)'(CRIT);
  localparam logic [CW-1:0] IU_LAST = CW'(IU_BITS - 1);
  localparam logic [ZW-1:0] GAP_L   = ZW'(GAP);

  logic [CW-1:0] rxCnt, txCnt;
  logic [ZW-1:0] zeroRun;
  logic          keep;
  logic          stuffZero;

  assign stuffZero = stuffEn && (rxCnt == '0) && !rxUbit;

  always_comb begin
    st   = '0;
    keep = 1'b1;
    if (!ubCopyEn) begin
      st.flush = 1'b1;
    end else begin
      if (stuffZero) begin
        if (level >= CRIT_L)                           keep = 1'b0;
        else if (level >= HIGH_L && zeroRun >= GAP_L)  keep = 1'b0;
      end
      st.push    = rxValid && keep && (level != FULL_L);
      st.pushBit = rxUbit;
      if (txReq) begin
        if (!stuffEn) begin
          st.pop   = (level != '0);
          st.emit0 = (level == '0);
        end else if (txCnt != '0) begin
          st.pop = 1'b1;
        end else if (level < LOW_L) begin
          st.emit0 = 1'b1;
        end else begin
          st.pop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ubCopyEn || !stuffEn) begin
      rxCnt   <= '0;
      txCnt   <= '0;
      zeroRun <= '0;
    end else begin
      if (rxValid) begin
        if (rxCnt != '0) begin
          rxCnt <= rxCnt - 1'b1;
        end else if (rxUbit) begin
          rxCnt   <= IU_LAST;
          zeroRun <= '0;
        end else if (zeroRun != GAP_L) begin
          zeroRun <= zeroRun + 1'b1;
        end
      end
      if (st.pop) begin
        if (txCnt != '0)  txCnt <= txCnt - 1'b1;
        else if (headBit) txCnt <= IU_LAST;
      end
    end
  end

  // R6: once an IU has started leaving, its remaining bits are stored
  assert_iu_whole_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txCnt != '0) |-> (level >= (AW+1)'(txCnt)));
  // R9: near full, no stuffing zero enters the FIFO
  assert_crit_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ubCopyEn && rxValid && stuffZero && level >= CRIT_L) |-> !st.push);
  // R7: pop and inserted zero never coincide
  assert_pop_or_emit_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(st.pop && st.emit0));
endmodule

// File: rtl/ubAutobuf.sv
module ubAutobuf
  import ubAutobufPkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int IU_BITS = 8,
  parameter int GAP     = 8,
  parameter int LOW     = 8,
  parameter int HIGH    = 48,
  parameter int CRIT    = 56
) (
  input  logic clk,
  input  logic rstN,
  input  logic ubCopyEn,
  input  logic csCopyEn,
  input  logic stuffEn,
  input  logic rxValid,
  input  logic rxUbit,
  input  logic rxCs,
  input  logic txReq,
  output logic txUbit,
  output logic txCs
);
  localparam int AW = $clog2(DEPTH);

  ctlStrobes_t st;
  logic [AW:0] level;
  logic        headBit;

  ubControl #(.DEPTH(DEPTH), .IU_BITS(IU_BITS), .GAP(GAP), .LOW(LOW),
              .HIGH(HIGH), .CRIT(CRIT)) uCtl (
    .clk(clk), .rstN(rstN), .ubCopyEn(ubCopyEn), .stuffEn(stuffEn),
    .rxValid(rxValid), .rxUbit(rxUbit), .txReq(txReq),
    .level(level), .headBit(headBit), .st(st));

  ubDatapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .rxValid(rxValid), .rxCs(rxCs),
    .csCopyEn(csCopyEn), .level(level), .headBit(headBit),
    .txUbit(txUbit), .txCs(txCs));
endmodule

// File: tb/sim_ubAutobuf.sv
module sim_ubAutobuf;
  localparam int PERIOD = 10;
  localparam int SEED   = 32'h5eed;

  logic clk = 1'b0, rstN = 1'b0;
  logic ubCopyEn = 1'b0, csCopyEn = 1'b0, stuffEn = 1'b0;
  logic rxValid = 1'b0, rxUbit = 1'b0, rxCs = 1'b0, txReq = 1'b0;
  logic txUbit, txCs;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic dirBits [0:255];  int dirN;
  logic expBits [0:255];  int expN;
  logic strBits [0:8191]; int strN;
  logic [7:0] sentIu [0:1023]; int iuN;
  int outIdx, pCnt, parseBad;
  logic [7:0] pAcc;

  ubAutobuf u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rxBit(input logic b, input logic c);
    rxValid = 1'b1; rxUbit = b; rxCs = c;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic txBit(output logic b);
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    b = txUbit;
  endtask

  task automatic flush();
    ubCopyEn = 1'b0; @(negedge clk); ubCopyEn = 1'b1;
  endtask

  task automatic addIu(input logic [7:0] v, input bit toExp);
    for (int i = 7; i >= 0; i--) begin
      dirBits[dirN++] = v[i];
      if (toExp) expBits[expN++] = v[i];
    end
  endtask

  task automatic addZeros(input int n, input int nExp);
    for (int i = 0; i < n; i++) dirBits[dirN++] = 1'b0;
    for (int i = 0; i < nExp; i++) expBits[expN++] = 1'b0;
  endtask

  // feed dirBits, then drain expN bits and count mismatches
  task automatic runDirected(input string tag);
    logic b; int bad = 0;
    for (int i = 0; i < dirN; i++) rxBit(dirBits[i], 1'b0);
    for (int i = 0; i < expN; i++) begin
      txBit(b);
      if (b != expBits[i]) bad++;
    end
    check(tag, bad, 0);
    dirN = 0; expN = 0;
  endtask

  function automatic void buildStream();
    strN = 0; iuN = 0;
    while (strN < 8000) begin
      int nIu = 1 + $urandom % 4;
      for (int k = 0; k < nIu; k++) begin
        logic [7:0] v = 8'h80 | 8'($urandom % 128);
        sentIu[iuN++] = v;
        for (int i = 7; i >= 0; i--) strBits[strN++] = v[i];
        if (k != nIu - 1)
          for (int z = $urandom % 4; z > 0; z--) strBits[strN++] = 1'b0;
      end
      for (int z = 8 + $urandom % 5; z > 0; z--) strBits[strN++] = 1'b0;
    end
  endfunction

  function automatic void parseBit(input logic b);
    if (pCnt == 0) begin
      if (b) begin pAcc = 8'h01; pCnt = 7; end
    end else begin
      pAcc = {pAcc[6:0], b};
      pCnt--;
      if (pCnt == 0) begin
        if (outIdx >= iuN || pAcc != sentIu[outIdx]) parseBad++;
        outIdx++;
      end
    end
  endfunction

  // random phase: rx and tx strobes with given percentages
  task automatic randomRun(input string tag, input int rxPct, input int txPct);
    int sIdx = 0; bit prevReq = 0;
    outIdx = 0; pCnt = 0; parseBad = 0;
    buildStream();
    flush();
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (prevReq) parseBit(txUbit);
      rxValid = ($urandom % 100) < rxPct;
      rxUbit  = (sIdx < strN) ? strBits[sIdx] : 1'b0;
      if (rxValid) sIdx++;
      txReq   = ($urandom % 100) < txPct;
      prevReq = txReq;
      @(negedge clk);
    end
    rxValid = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (prevReq) parseBit(txUbit);
      txReq = 1'b1; prevReq = 1'b1;
      @(negedge clk);
    end
    txReq = 1'b0;
    check({tag, " R6 IU order/content"}, parseBad, 0);
    check({tag, " R6 IUs delivered"}, int'(outIdx > 100), 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic b;
    void'($urandom(SEED));
    dirN = 0; expN = 0;
    repeat (3) @(negedge clk);
    check("R1 txUbit after reset", txUbit, 0);
    check("R1 txCs after reset", txCs, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 channel-status copy
    csCopyEn = 1'b1;
    rxBit(1'b0, 1'b1);
    check("R3 cs copied", txCs, 1);
    rxCs = 1'b0; @(negedge clk);
    check("R3 cs held without strobe", txCs, 1);
    csCopyEn = 1'b0; @(negedge clk);
    check("R3 cs gated off", txCs, 0);

    // R2 disabled copy stores nothing
    ubCopyEn = 1'b0;
    for (int i = 0; i < 5; i++) rxBit(1'b1, 1'b0);
    check("R2 txUbit while disabled", txUbit, 0);
    ubCopyEn = 1'b1;
    txBit(b);
    check("R2 nothing stored while disabled", b, 0);

    // R4 plain mode order
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        dirBits[i] = 1'($urandom % 2); rxBit(dirBits[i], 1'b0);
      end
      for (int i = 0; i < 20; i++) begin
        txBit(b); if (b != dirBits[i]) bad++;
      end
      check("R4 plain order", bad, 0);
    end
    txBit(b);
    check("R5 empty gives 0", b, 0);

    // R5 full drops
    begin
      int bad = 0;
      for (int i = 0; i < 70; i++) begin
        dirBits[i] = (i < 64) ? 1'($urandom % 2) : 1'b1; rxBit(dirBits[i], 1'b0);
      end
      for (int i = 0; i < 64; i++) begin
        txBit(b); if (b != dirBits[i]) bad++;
      end
      check("R5 first 64 kept", bad, 0);
      txBit(b);
      check("R5 overflow bits discarded", b, 0);
    end
    dirN = 0;

    // stuffing mode directed
    stuffEn = 1'b1; flush();
    txBit(b);
    check("R7 empty inserts 0", b, 0);
    rxBit(1'b1, 0); rxBit(1'b0, 0); rxBit(1'b1, 0); rxBit(1'b1, 0); rxBit(1'b0, 0);
    txBit(b);
    check("R7 partial IU not started", b, 0);
    rxBit(1'b1, 0); rxBit(1'b0, 0); rxBit(1'b1, 0);
    addIu(8'hB5, 1); dirN = 0;
    runDirected("R6 IU after insertion");

    flush();
    for (int i = 0; i < 2; i++) addIu(8'h80 | 8'(i * 17 + 3), 1);
    addZeros(12, 12); addIu(8'hC3, 1);
    runDirected("R10 zeros kept below threshold");

    flush();
    for (int i = 0; i < 6; i++) addIu(8'h80 | 8'(i * 21 + 5), 1);
    addZeros(12, 8); addIu(8'hE7, 1);
    runDirected("R8 gap trimmed to 8");

    flush();
    for (int i = 0; i < 7; i++) addIu(8'h81 | 8'(i * 9), 1);
    addZeros(3, 0); addIu(8'h9A, 1);
    runDirected("R9 inter-IU zeros dropped");

    randomRun("rx faster", 50, 46);
    randomRun("tx faster", 40, 50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule